// File: doc/BRIEF.md
# Flyby DMA Request Controller

This block runs one flyby DMA channel, in which each word passes straight between an external I/O device and external memory in a single bus transaction, with no internal staging. Software first loads a transfer control set: a start address, a signed-free address step, a word count, a direction flag and a flag saying the far end is an external I/O device. It then enables the channel.

The device asks for each word by pulling an active-low request line. The block synchronizes that line to the core clock, detects each high-to-low transition and adds it to a small pending counter. While the channel owns the bus and requests are pending, it issues one memory transaction per request. It holds the transaction until memory signals ready. When the device is the data source, the block performs a memory write and raises the I/O-enable strobe so the device drives the data bus. When the device is the sink, the block performs a memory read and raises the flyby strobe so the device latches the data. After each word the address steps and the count drops. The last word produces a one-cycle done pulse.

Top module: `flyby_dma_ctrl`

## Requirements
- R1: Only a high-to-low transition of `reqN` starts a request; a line held low starts no more, and a transition whose stable low level is first seen at rising edge k (reqN changed between edges k-1 and k) brings `memReq` high no earlier than after rising edge k+3 (two synchronizer stages plus the pending counter and the transaction state register).
- R2: Every counted transition produces exactly one memory transaction; up to 15 transitions may be outstanding before any transaction runs, and none of them is lost.
- R3: A transition counted while 15 requests are already pending, with no transaction completing in that cycle, leaves the pending count at 15 and sets `overflow`, which stays high until the next `cfgLoad`.
- R4: A transition and a transaction completion in the same cycle leave the pending count unchanged, so the total number of transactions still equals the number of counted transitions.
- R5: A transaction starts only when requests are pending, `busGrant` and `chanEnable` are high and the remaining count is non-zero; `memReq` then stays high until a cycle with `memReady` high and is low in the following cycle, as are both strobes.
- R6: With the direction flag `cfgToMem` = 1 (device to memory), a transaction drives `memWrite` = 1 and `ioEnable` = 1, and `flybyStrobe` stays 0.
- R7: With `cfgToMem` = 0 (memory to device), a transaction drives `memWrite` = 0 and `ioEnable` = 0; `flybyStrobe` is high only while the transaction runs, `busGrant` is high and the loaded target flag `cfgTargetIo` is 1, and is 0 otherwise.
- R8: `memAddr` equals the loaded start address after `cfgLoad` and advances by the loaded step after every completed word.
- R9: The completion of the last counted word raises `done` for exactly one cycle, clears all pending requests, and later transitions start no transaction until the next `cfgLoad`.
- R10: `cfgLoad` loads the control set, clears pending requests and `overflow`, and ends any running transaction at once; transitions that arrive while `chanEnable` is low are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | One-cycle pulse that loads the control set |
| cfgAddr | input | ADDR_W | Start address of the transfer |
| cfgStep | input | ADDR_W | Address increment per word |
| cfgCount | input | CNT_W | Number of words |
| cfgToMem | input | 1 | 1: device to memory, 0: memory to device |
| cfgTargetIo | input | 1 | 1: far end is an external I/O device |
| chanEnable | input | 1 | Channel enable |
| busGrant | input | 1 | Channel currently owns the external bus |
| reqN | input | 1 | Asynchronous active-low request from the device |
| memReady | input | 1 | Memory completes the current transaction |
| memReq | output | 1 | A memory transaction is running |
| memWrite | output | 1 | Running transaction is a memory write |
| memAddr | output | ADDR_W | Address of the current word |
| ioEnable | output | 1 | Device drives the data bus |
| flybyStrobe | output | 1 | Device latches the data bus |
| done | output | 1 | One-cycle pulse after the last word |
| overflow | output | 1 | Sticky lost-request flag |

## Verification
The embedded assertions watch, on every cycle, that a transaction ends in the cycle after ready. They also check that the two strobes are never high together, that the flyby strobe only appears with bus ownership and an I/O target, and that the pending counter saturates into the overflow flag. They further check that the address steps by the loaded increment and that done never lasts two cycles. Whether every request edge turns into exactly one transaction, and whether a held-low line, a disabled channel or an exhausted count leaves requests uncounted, shows only over whole scenarios. The bench covers these with request bursts, a 16-deep pile-up, coincident edges and completions, and aborts by reload, compared cycle by cycle against its reference model.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } fdmaState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new control set
    logic advance;  // one word finished: step address, drop count
  } dpCmd_t;

endpackage

// File: rtl/fdma_req_capture.sv
module fdma_req_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqN,
  output logic reqEdge
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b1;
        else       syncQ[0] <= reqN;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign reqEdge = prevQ & ~syncQ[SYNC_STAGES-1];

  // R1
  edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqEdge |=> !reqEdge);

endmodule

// File: rtl/fdma_datapath.sv
module fdma_datapath
  import fdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgStep,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              cfgToMem,
  input  logic              cfgTargetIo,
  output logic [ADDR_W-1:0] curAddr,
  output logic              xferToMem,
  output logic              targetIo,
  output logic              countZero,
  output logic              lastWord
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] stepQ;
  logic [CNT_W-1:0]  countQ;
  logic              toMemQ;
  logic              targetIoQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      stepQ     <= '0;
      countQ    <= '0;
      toMemQ    <= 1'b0;
      targetIoQ <= 1'b0;
    end else if (cmd.load) begin
      addrQ     <= cfgAddr;
      stepQ     <= cfgStep;
      countQ    <= cfgCount;
      toMemQ    <= cfgToMem;
      targetIoQ <= cfgTargetIo;
    end else if (cmd.advance) begin
      addrQ  <= addrQ + stepQ;
      countQ <= countQ - CNT_ONE;
    end
  end

  assign curAddr   = addrQ;
  assign xferToMem = toMemQ;
  assign targetIo  = targetIoQ;
  assign countZero = (countQ == '0);
  assign lastWord  = (countQ == CNT_ONE);

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.advance && !cmd.load) |=> curAddr == $past(curAddr) + $past(stepQ));

  // R8
  addr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> curAddr == $past(cfgAddr));

endmodule

// File: rtl/fdma_control.sv
module fdma_control
  import fdma_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   cfgLoad,
  input  logic   chanEnable,
  input  logic   busGrant,
  input  logic   reqEdge,
  input  logic   memReady,
  input  logic   xferToMem,
  input  logic   targetIo,
  input  logic   countZero,
  input  logic   lastWord,
  output dpCmd_t cmd,
  output logic   memReq,
  output logic   memWrite,
  output logic   ioEnable,
  output logic   flybyStrobe,
  output logic   done,
  output logic   overflow
);

  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};
  localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

  fdmaState_t        stateQ, stateD;
  logic [PEND_W-1:0] pendQ, pendD;
  logic              ovfQ, ovfD;
  logic              doneQ;

  logic armed, countReq, finishWord, lastFinish, inXfer;

  assign inXfer     = (stateQ == ST_XFER);
  assign armed      = chanEnable & ~countZero;
  assign countReq   = reqEdge & armed & ~cfgLoad;
  assign finishWord = inXfer & memReady & ~cfgLoad;
  assign lastFinish = finishWord & lastWord;

  // pending request counter
  always_comb begin
    pendD = pendQ;
    ovfD  = ovfQ;
    if (cfgLoad) begin
      pendD = '0;
      ovfD  = 1'b0;
    end else if (lastFinish) begin
      pendD = '0;
    end else begin
      unique case ({countReq, finishWord})
        2'b10: begin
          if (pendQ == PEND_MAX) ovfD = 1'b1;
          else                   pendD = pendQ + PEND_ONE;
        end
        2'b01:   pendD = pendQ - PEND_ONE;
        default: pendD = pendQ;
      endcase
    end
  end

  // transaction sequencer
  always_comb begin
    stateD = stateQ;
    if (cfgLoad) begin
      stateD = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (pendQ != '0 && busGrant && armed) stateD = ST_XFER;
        ST_XFER: if (memReady) stateD = ST_IDLE;
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      pendQ  <= '0;
      ovfQ   <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      pendQ  <= pendD;
      ovfQ   <= ovfD;
      doneQ  <= lastFinish;
    end
  end

  assign cmd.load    = cfgLoad;
  assign cmd.advance = finishWord;

  assign memReq      = inXfer;
  assign memWrite    = inXfer & xferToMem;
  assign ioEnable    = inXfer & xferToMem;
  assign flybyStrobe = inXfer & ~xferToMem & busGrant & targetIo;
  assign done        = doneQ;
  assign overflow    = ovfQ;

  // R5
  end_after_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady) |=> (!memReq && !ioEnable && !flybyStrobe));

  // R5
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(busGrant && chanEnable && pendQ != '0));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ == PEND_MAX && countReq && !finishWord && !lastFinish)
      |=> (pendQ == PEND_MAX && overflow));

  // R3
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !cfgLoad) |=> overflow);

  // R4
  pend_balance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countReq && finishWord && !lastFinish) |=> $stable(pendQ));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ioEnable && flybyStrobe));

  // R7
  flyby_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    flybyStrobe |-> (busGrant && targetIo && !memWrite));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/flyby_dma_ctrl.sv
module flyby_dma_ctrl
  import fdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int PEND_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgStep,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              cfgToMem,
  input  logic              cfgTargetIo,
  input  logic              chanEnable,
  input  logic              busGrant,
  input  logic              reqN,
  input  logic              memReady,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic              ioEnable,
  output logic              flybyStrobe,
  output logic              done,
  output logic              overflow
);

  dpCmd_t cmd;
  logic   reqEdge;
  logic   xferToMem, targetIo, countZero, lastWord;

  fdma_req_capture #(.SYNC_STAGES(SYNC_STAGES)) capture_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqN    (reqN),
    .reqEdge (reqEdge)
  );

  fdma_control #(.PEND_W(PEND_W)) control_i (
    .clk         (clk),
    .rstN        (rstN),
    .cfgLoad     (cfgLoad),
    .chanEnable  (chanEnable),
    .busGrant    (busGrant),
    .reqEdge     (reqEdge),
    .memReady    (memReady),
    .xferToMem   (xferToMem),
    .targetIo    (targetIo),
    .countZero   (countZero),
    .lastWord    (lastWord),
    .cmd         (cmd),
    .memReq      (memReq),
    .memWrite    (memWrite),
    .ioEnable    (ioEnable),
    .flybyStrobe (flybyStrobe),
    .done        (done),
    .overflow    (overflow)
  );

  fdma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) datapath_i (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .cfgAddr     (cfgAddr),
    .cfgStep     (cfgStep),
    .cfgCount    (cfgCount),
    .cfgToMem    (cfgToMem),
    .cfgTargetIo (cfgTargetIo),
    .curAddr     (memAddr),
    .xferToMem   (xferToMem),
    .targetIo    (targetIo),
    .countZero   (countZero),
    .lastWord    (lastWord)
  );

endmodule

// File: tb/flyby_dma_ctrl_tb_top.sv
`timescale 1ns/1ps
module flyby_dma_ctrl_tb_top;

  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgLoad = 1'b0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic [ADDR_W-1:0] cfgStep = '0;
  logic [CNT_W-1:0]  cfgCount = '0;
  logic              cfgToMem = 1'b0;
  logic              cfgTargetIo = 1'b0;
  logic              chanEnable = 1'b0;
  logic              busGrant = 1'b0;
  logic              reqN = 1'b1;
  logic              memReady = 1'b0;
  logic              memReq, memWrite, ioEnable, flybyStrobe, done, overflow;
  logic [ADDR_W-1:0] memAddr;

  int checks = 0;
  int fails  = 0;
  int readyLat = 1;
  int waitCnt = 0;
  int txTotal = 0;
  int doneTotal = 0;
  int flybySeen = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  flyby_dma_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgAddr(cfgAddr),
    .cfgStep(cfgStep), .cfgCount(cfgCount), .cfgToMem(cfgToMem),
    .cfgTargetIo(cfgTargetIo), .chanEnable(chanEnable), .busGrant(busGrant),
    .reqN(reqN), .memReady(memReady), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .ioEnable(ioEnable), .flybyStrobe(flybyStrobe),
    .done(done), .overflow(overflow)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int  mS1 = 1, mS2 = 1, mPrev = 1, mPend = 0, mBusy = 0, mDone = 0, mOvf = 0;
  int  mCnt = 0, mToMem = 0, mTio = 0;
  longint mAddr = 0, mStep = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mPrev = 1; mPend = 0; mBusy = 0; mDone = 0; mOvf = 0;
      mCnt = 0; mToMem = 0; mTio = 0; mAddr = 0; mStep = 0;
    end else begin
      bit edgeSeen, armed, inc, fin, last;
      edgeSeen = (mPrev == 1) && (mS2 == 0);
      armed    = chanEnable && (mCnt != 0);
      inc      = edgeSeen && armed && !cfgLoad;
      fin      = (mBusy == 1) && memReady && !cfgLoad;
      last     = fin && (mCnt == 1);
      mPrev = mS2; mS2 = mS1; mS1 = reqN;
      mDone = last;
      if (cfgLoad) begin
        mPend = 0; mOvf = 0; mBusy = 0;
        mAddr = cfgAddr; mStep = cfgStep; mCnt = cfgCount;
        mToMem = cfgToMem; mTio = cfgTargetIo;
      end else begin
        int startNow;
        startNow = (mBusy == 0) && (mPend > 0) && busGrant && armed;
        if (last) mPend = 0;
        else if (inc && !fin) begin
          if (mPend == 15) mOvf = 1; else mPend++;
        end else if (fin && !inc) mPend--;
        if (fin) begin
          mAddr = (mAddr + mStep) & 64'hFFFF_FFFF;
          mCnt--;
        end
        if (mBusy == 1) mBusy = memReady ? 0 : 1;
        else if (startNow) mBusy = 1;
      end
    end
  end

  // compare every cycle away from the clock edge
  always @(negedge clk) begin
    if (rstN) begin
      cycles++;
      check("R5", "memReq",      memReq,      mBusy);
      check("R6", "memWrite",    memWrite,    mBusy && mToMem);
      check("R6", "ioEnable",    ioEnable,    mBusy && mToMem);
      check("R7", "flybyStrobe", flybyStrobe, mBusy && !mToMem && busGrant && mTio);
      check("R8", "memAddr",     memAddr,     mAddr);
      check("R9", "done",        done,        mDone);
      check("R3", "overflow",    overflow,    mOvf);
      if (memReq && memReady) txTotal++;
      if (done) doneTotal++;
      if (flybyStrobe) flybySeen++;
    end
  end

  // memory responder
  always @(posedge clk) begin
    #1;
    if (memReq) begin
      memReady = (waitCnt >= readyLat);
      waitCnt++;
    end else begin
      memReady = 1'b0;
      waitCnt  = 0;
    end
  end

  // watchdog
  initial begin
    #(5ns * 100000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic loadCfg(input logic [31:0] a, input logic [31:0] s,
                         input int n, input logic toMem, input logic tio);
    cfgAddr = a; cfgStep = s; cfgCount = CNT_W'(n);
    cfgToMem = toMem; cfgTargetIo = tio; cfgLoad = 1'b1;
    tick(1);
    cfgLoad = 1'b0;
  endtask

  task automatic pulse(input int lowCyc, input int highCyc);
    reqN = 1'b0; tick(lowCyc);
    reqN = 1'b1; tick(highCyc);
  endtask

  initial begin
    int tx0, d0, riseAt;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // reset state
    check("R5", "reset memReq", memReq, 0);
    check("R3", "reset overflow", overflow, 0);
    check("R9", "reset done", done, 0);

    // S1: device to memory, three requests
    loadCfg(32'h1000, 32'h4, 8, 1'b1, 1'b1);
    check("R8", "start address", memAddr, 32'h1000);
    chanEnable = 1'b1; busGrant = 1'b1; readyLat = 1;
    tx0 = txTotal;
    reqN = 1'b0;            // seen low at the next rising edge (k)
    riseAt = 0;
    for (int i = 0; i < 8; i++) begin
      tick(1);
      if (i == 1) reqN = 1'b1;
      if (memReq && riseAt == 0) riseAt = i + 1;
    end
    check("R1", "edges until memReq", riseAt, 4);
    pulse(2, 2); pulse(2, 2);
    tick(20);
    check("R2", "S1 transactions", txTotal - tx0, 3);
    check("R8", "address after 3 words", memAddr, 32'h100C);

    // S2: line held low gives one request
    tx0 = txTotal;
    reqN = 1'b0; tick(30); reqN = 1'b1; tick(10);
    check("R1", "held low transactions", txTotal - tx0, 1);

    // S3: 16 requests without the bus
    loadCfg(32'h8000, 32'h10, 40, 1'b0, 1'b1);
    busGrant = 1'b0;
    tx0 = txTotal;
    for (int i = 0; i < 15; i++) pulse(1, 2);
    tick(6);
    check("R3", "no overflow at 15", overflow, 0);
    check("R5", "no transaction without grant", txTotal - tx0, 0);
    pulse(1, 2); tick(6);
    check("R3", "overflow at 16", overflow, 1);
    busGrant = 1'b1; tick(5); busGrant = 1'b0; tick(4); busGrant = 1'b1;
    tick(80);
    check("R2", "15 held requests drained", txTotal - tx0, 15);
    check("R7", "flyby seen with I/O target", flybySeen > 0, 1);

    // S4: edges coinciding with completions
    readyLat = 0;
    tx0 = txTotal;
    for (int i = 0; i < 10; i++) pulse(1, 1);
    tick(30);
    check("R4", "coincident edges", txTotal - tx0, 10);

    // S5: memory target, last word, done and later requests
    loadCfg(32'h200, 32'h8, 3, 1'b0, 1'b0);
    check("R10", "overflow cleared by load", overflow, 0);
    flybySeen = 0; tx0 = txTotal; d0 = doneTotal;
    for (int i = 0; i < 3; i++) pulse(2, 3);
    tick(20);
    check("R7", "no flyby without I/O target", flybySeen, 0);
    check("R9", "done pulses", doneTotal - d0, 1);
    tx0 = txTotal;
    pulse(2, 2); pulse(2, 2); tick(15);
    check("R9", "requests after done", txTotal - tx0, 0);

    // S6: disabled channel ignores requests
    loadCfg(32'h300, 32'h4, 5, 1'b1, 1'b1);
    chanEnable = 1'b0; tx0 = txTotal;
    pulse(2, 2); pulse(2, 2); tick(6);
    chanEnable = 1'b1; tick(15);
    check("R10", "disabled requests", txTotal - tx0, 0);

    // S7: reload aborts a running transaction
    readyLat = 8; tx0 = txTotal;
    pulse(2, 2); tick(3);
    check("R5", "transaction held until ready", memReq, 1);
    loadCfg(32'h400, 32'h4, 5, 1'b1, 1'b1);
    check("R10", "abort memReq", memReq, 0);
    check("R10", "reload address", memAddr, 32'h400);
    tick(15);
    check("R10", "aborted transactions", txTotal - tx0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule